// File: doc/BRIEF.md
# Program Counter Sequencer with Return-Address Stack

This block holds the program counter of a small processor and decides its next value each clock from four control strobes: advance, branch, subroutine entry and subroutine exit. A dedicated last-in-first-out memory keeps return addresses. On a subroutine entry the address after the current one is saved and the branch target is loaded into the counter on the same clock edge, so entry costs no extra cycle. On an exit the most recently saved address is taken back into the counter.

The stack holds 32 return addresses of 16 bits each by default, which covers a 64K-instruction program space. Two sticky error flags record an entry attempted with every slot in use and an exit attempted with no slot in use. Both flags stay set until reset. A synchronous active-high reset clears the counter, the stack occupancy and both flags. The data stack, instruction fetch and arithmetic are handled elsewhere.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next cycle shows `pc_o` = 0, `depth_o` = 0, `ovf_o` = 0 and `unf_o` = 0.
- R2: With only `adv_i` asserted among the four controls, `pc_o` becomes the previous `pc_o` + 1, modulo 2^16 (0xFFFF advances to 0x0000).
- R3: With `br_i` asserted and neither `call_i` nor `ret_i`, `pc_o` becomes `tgt_i`, whatever `adv_i` is.
- R4: With `call_i` asserted and `depth_o` below 32, one edge pushes (`pc_o` + 1) mod 2^16 onto the stack, loads `tgt_i` into `pc_o` and raises `depth_o` by one.
- R5: With `ret_i` asserted, `call_i` low and `depth_o` above 0, one edge loads the most recently pushed address that is still held into `pc_o` and lowers `depth_o` by one. Addresses come back in the reverse order of their pushes.
- R6: With `call_i` asserted and `depth_o` equal to 32, `ovf_o` is set, `depth_o` and the stored addresses are unchanged, and `pc_o` becomes `pc_o` + 1.
- R7: With `ret_i` asserted, `call_i` low and `depth_o` equal to 0, `unf_o` is set, `depth_o` stays 0, and `pc_o` becomes `pc_o` + 1.
- R8: Once set, `ovf_o` and `unf_o` stay high until reset.
- R9: When `call_i` and `ret_i` are asserted together, the cycle behaves exactly as a call (R4 or R6), and `ret_i` has no effect.
- R10: With all four controls low, `pc_o` and `depth_o` keep their values.
- R11: `empty_o` is high exactly when `depth_o` = 0, and `full_o` is high exactly when `depth_o` = 32. `depth_o` never exceeds 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| adv_i | input | 1 | Advance to the next address |
| br_i | input | 1 | Load the target address |
| call_i | input | 1 | Save the return address and load the target |
| ret_i | input | 1 | Restore the counter from the stack |
| tgt_i | input | 16 | Target address for branch and call |
| pc_o | output | 16 | Current program counter |
| depth_o | output | 6 | Number of stored return addresses |
| empty_o | output | 1 | No return addresses stored |
| full_o | output | 1 | Every stack slot in use |
| ovf_o | output | 1 | Sticky: a call was made with the stack full |
| unf_o | output | 1 | Sticky: a return was made with the stack empty |

## Verification
The clocked properties assume that every control strobe and the target bus carry known 0/1 values at each rising edge, and that `rst` is high on the first edge so that the history seen by `$past` starts from a defined state. The bench drives every input on the falling edge, from reset onward, and never leaves a bit undriven. It samples outputs 1 ns after the rising edge. The bench also steers the stack through its full and empty boundaries on purpose, because the push, pop, overflow and underflow properties apply only at the occupancy each one names.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

  // Source selected for the next program counter value
  typedef enum logic [1:0] {
    NXT_HOLD = 2'd0,
    NXT_INC  = 2'd1,
    NXT_TGT  = 2'd2,
    NXT_POP  = 2'd3
  } nxt_sel_t;

endpackage

// File: rtl/pcseq_ctrl.sv
module pcseq_ctrl
  import pcseq_pkg::*;
(
  input  logic     adv,
  input  logic     br,
  input  logic     call,
  input  logic     ret,
  input  logic     full,
  input  logic     empty,
  output nxt_sel_t sel,
  output logic     push,
  output logic     pop,
  output logic     ovf_set,
  output logic     unf_set
);

  // Priority: call > return > branch > advance > hold
  always_comb begin
    sel     = NXT_HOLD;
    push    = 1'b0;
    pop     = 1'b0;
    ovf_set = 1'b0;
    unf_set = 1'b0;
    if (call) begin
      if (full) begin
        sel     = NXT_INC;
        ovf_set = 1'b1;
      end else begin
        sel  = NXT_TGT;
        push = 1'b1;
      end
    end else if (ret) begin
      if (empty) begin
        sel     = NXT_INC;
        unf_set = 1'b1;
      end else begin
        sel = NXT_POP;
        pop = 1'b1;
      end
    end else if (br) begin
      sel = NXT_TGT;
    end else if (adv) begin
      sel = NXT_INC;
    end
  end

endmodule

// File: rtl/pcseq_lifo.sv
module pcseq_lifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic                         pop,
  input  logic [WIDTH-1:0]             din,
  output logic [WIDTH-1:0]             top,
  output logic [$clog2(DEPTH+1)-1:0]   count
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [CNT_W-1:0] count_q;
  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] rd_idx;

  assign wr_idx = count_q[IDX_W-1:0];
  assign rd_idx = wr_idx - 1'b1;

  // Storage has no reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_idx] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst)       count_q <= '0;
    else if (push) count_q <= count_q + 1'b1;
    else if (pop)  count_q <= count_q - 1'b1;
  end

  // Asynchronous read of the top entry so a return completes in one edge
  assign top   = mem[rd_idx];
  assign count = count_q;

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcseq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 32,
  localparam int CNT_W = $clog2(DEPTH+1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv_i,
  input  logic              br_i,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic [ADDR_W-1:0] tgt_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [CNT_W-1:0]  depth_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              ovf_o,
  output logic              unf_o
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] pc_inc;
  logic [ADDR_W-1:0] stk_top;
  logic [CNT_W-1:0]  cnt;
  logic              is_full, is_empty;
  logic              push, pop, ovf_set, unf_set;
  logic              ovf_q, unf_q;
  nxt_sel_t          sel;

  assign pc_inc   = pc_q + 1'b1;
  assign is_full  = (cnt == FULL_CNT);
  assign is_empty = (cnt == '0);

  pcseq_ctrl u_ctrl (
    .adv     (adv_i),
    .br      (br_i),
    .call    (call_i),
    .ret     (ret_i),
    .full    (is_full),
    .empty   (is_empty),
    .sel     (sel),
    .push    (push),
    .pop     (pop),
    .ovf_set (ovf_set),
    .unf_set (unf_set)
  );

  pcseq_lifo #(.WIDTH(ADDR_W), .DEPTH(DEPTH)) u_lifo (
    .clk   (clk),
    .rst   (rst),
    .push  (push),
    .pop   (pop),
    .din   (pc_inc),
    .top   (stk_top),
    .count (cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
    end else begin
      unique case (sel)
        NXT_INC:  pc_q <= pc_inc;
        NXT_TGT:  pc_q <= tgt_i;
        NXT_POP:  pc_q <= stk_top;
        default:  pc_q <= pc_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_q | ovf_set;
      unf_q <= unf_q | unf_set;
    end
  end

  assign pc_o    = pc_q;
  assign depth_o = cnt;
  assign empty_o = is_empty;
  assign full_o  = is_full;
  assign ovf_o   = ovf_q;
  assign unf_o   = unf_q;

endmodule

// File: rtl/pcseq_chk.sv
module pcseq_chk #(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 32,
  localparam int CNT_W = $clog2(DEPTH+1)
) (
  input logic              clk,
  input logic              rst,
  input logic              adv_i,
  input logic              br_i,
  input logic              call_i,
  input logic              ret_i,
  input logic [ADDR_W-1:0] tgt_i,
  input logic [ADDR_W-1:0] pc_o,
  input logic [CNT_W-1:0]  depth_o,
  input logic              empty_o,
  input logic              full_o,
  input logic              ovf_o,
  input logic              unf_o
);

  localparam logic [CNT_W-1:0] TOP = CNT_W'(DEPTH);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (pc_o == '0 && depth_o == '0 && !ovf_o && !unf_o));

  // R2
  advance_chk: assert property (@(posedge clk) disable iff (rst)
    (adv_i && !br_i && !call_i && !ret_i) |=> pc_o == ADDR_W'($past(pc_o) + 1'b1));

  // R3
  branch_chk: assert property (@(posedge clk) disable iff (rst)
    (br_i && !call_i && !ret_i) |=> pc_o == $past(tgt_i));

  // R4
  call_push_chk: assert property (@(posedge clk) disable iff (rst)
    (call_i && depth_o != TOP) |=> (pc_o == $past(tgt_i) && depth_o == $past(depth_o) + 1'b1));

  // R5
  ret_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (ret_i && !call_i && depth_o != '0) |=> depth_o == $past(depth_o) - 1'b1);

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (call_i && depth_o == TOP) |=>
      (ovf_o && depth_o == TOP && pc_o == ADDR_W'($past(pc_o) + 1'b1)));

  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    (ret_i && !call_i && depth_o == '0) |=>
      (unf_o && depth_o == '0 && pc_o == ADDR_W'($past(pc_o) + 1'b1)));

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_o |=> ovf_o);

  // R8
  unf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    unf_o |=> unf_o);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!adv_i && !br_i && !call_i && !ret_i) |=> ($stable(pc_o) && $stable(depth_o)));

  // R11
  depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (depth_o <= TOP && (empty_o == (depth_o == '0)) && (full_o == (depth_o == TOP))));

endmodule

bind pc_sequencer pcseq_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .adv_i   (adv_i),
  .br_i    (br_i),
  .call_i  (call_i),
  .ret_i   (ret_i),
  .tgt_i   (tgt_i),
  .pc_o    (pc_o),
  .depth_o (depth_o),
  .empty_o (empty_o),
  .full_o  (full_o),
  .ovf_o   (ovf_o),
  .unf_o   (unf_o)
);

// File: tb/pc_sequencer_bench.sv
`timescale 1ns/1ps
module pc_sequencer_bench;

  localparam int AW = 16;
  localparam int DP = 32;
  localparam int CW = $clog2(DP+1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          adv_i = 1'b0, br_i = 1'b0, call_i = 1'b0, ret_i = 1'b0;
  logic [AW-1:0] tgt_i = '0;
  logic [AW-1:0] pc_o;
  logic [CW-1:0] depth_o;
  logic          empty_o, full_o, ovf_o, unf_o;

  int checks = 0;
  int fails  = 0;

  // Reference model state
  logic [AW-1:0] m_pc;
  logic [AW-1:0] m_stk [DP];
  int            m_dep;
  logic          m_ovf, m_unf;
  logic [15:0]   lfsr = 16'hACE1;

  always #2 clk = ~clk;

  pc_sequencer u_pc_sequencer (
    .clk(clk), .rst(rst), .adv_i(adv_i), .br_i(br_i), .call_i(call_i),
    .ret_i(ret_i), .tgt_i(tgt_i), .pc_o(pc_o), .depth_o(depth_o),
    .empty_o(empty_o), .full_o(full_o), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk({tag, " pc"}, 32'(pc_o), 32'(m_pc));
    chk({tag, " depth"}, 32'(depth_o), 32'(m_dep));
    chk({tag, " ovf R8"}, 32'(ovf_o), 32'(m_ovf));
    chk({tag, " unf R8"}, 32'(unf_o), 32'(m_unf));
    chk("R11 empty", 32'(empty_o), 32'(m_dep == 0));
    chk("R11 full", 32'(full_o), 32'(m_dep == DP));
  endtask

  // One clock with the given controls, then model update and comparison
  task automatic op(input logic a, input logic b, input logic c, input logic r,
                    input logic [AW-1:0] t);
    string tag;
    @(negedge clk);
    adv_i = a; br_i = b; call_i = c; ret_i = r; tgt_i = t;
    @(posedge clk);
    #1;
    if (c) begin
      tag = r ? "R9 call+ret" : "R4 call";
      if (m_dep == DP) begin
        tag = r ? "R9 call+ret full" : "R6 call full";
        m_ovf = 1'b1;
        m_pc = m_pc + 1'b1;
      end else begin
        m_stk[m_dep] = m_pc + 1'b1;
        m_dep++;
        m_pc = t;
      end
    end else if (r) begin
      if (m_dep == 0) begin
        tag = "R7 ret empty";
        m_unf = 1'b1;
        m_pc = m_pc + 1'b1;
      end else begin
        tag = "R5 ret";
        m_dep--;
        m_pc = m_stk[m_dep];
      end
    end else if (b) begin
      tag = "R3 branch";
      m_pc = t;
    end else if (a) begin
      tag = "R2 advance";
      m_pc = m_pc + 1'b1;
    end else begin
      tag = "R10 idle";
    end
    compare(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; adv_i = 0; br_i = 0; call_i = 0; ret_i = 0;
    @(posedge clk);
    #1;
    rst = 1'b0;
    m_pc = '0; m_dep = 0; m_ovf = 1'b0; m_unf = 1'b0;
    compare("R1 reset");
  endtask

  function automatic logic [15:0] nxt(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R7 underflow at reset, then R8 stickiness
    op(0, 0, 0, 1, 16'h0000);
    op(0, 0, 0, 0, 16'h0000);
    do_reset();
    // R2 wrap
    op(0, 1, 0, 0, 16'hFFFE);
    op(1, 0, 0, 0, 16'h0000);
    op(1, 0, 0, 0, 16'h0000);
    // R4 call from 0xFFFF pushes wrapped 0
    op(0, 1, 0, 0, 16'hFFFF);
    op(0, 0, 1, 0, 16'h1234);
    op(0, 0, 0, 1, 16'h0000);
    // Fill to full with distinct return addresses, then overflow (R6)
    for (int i = 0; i < DP; i++) op(0, 0, 1, 0, 16'(16'h0100 + i * 16'h0111));
    op(0, 0, 1, 0, 16'h7777);
    op(0, 0, 1, 1, 16'h5555);
    op(0, 0, 0, 0, 16'h0000);
    // LIFO unwind (R5) then underflow
    for (int i = 0; i < DP + 1; i++) op(0, 0, 0, 1, 16'hDEAD);
    // Sweep all 16 control combinations at empty, mid and full occupancy
    for (int lvl = 0; lvl < 3; lvl++) begin
      for (int cmb = 0; cmb < 16; cmb++) begin
        do_reset();
        for (int k = 0; k < (lvl == 0 ? 0 : (lvl == 1 ? 5 : DP)); k++)
          op(0, 0, 1, 0, 16'(16'h2000 + k * 16'h0043));
        op(cmb[0], cmb[1], cmb[2], cmb[3], 16'(16'h4321 + cmb));
        op(0, 0, 0, 1, 16'h0000);
      end
    end
    // Pseudo-random mix
    do_reset();
    for (int n = 0; n < 6000; n++) begin
      lfsr = nxt(lfsr);
      op(lfsr[0], lfsr[1] & lfsr[4], lfsr[2] & lfsr[5], lfsr[3] & lfsr[6], nxt(lfsr));
      if (n % 1500 == 1499) do_reset();
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule